// File: doc/BRIEF.md
# Frame-Synchronous Scrambler with Parity Insertion

This block sits on the transmit side of a byte-interleaved optical line stream. It accepts one byte per enabled clock together with a frame-start flag. It tracks the byte position inside the frame and whitens the payload with a scrambler that restarts in every frame. It also computes a byte-wide even parity over everything it sent in the previous frame and drops that parity into the section parity slot of the current frame.

The frame is nine rows of `90*STS_N` bytes. The first `3*STS_N` bytes of a frame are the framing pattern and trace bytes, and they leave the block untouched. The scrambler is loaded with all ones on the byte that follows them, and it runs to the end of the frame. The parity slot is the first byte of row two. Its incoming value is discarded, and the stored parity goes into the scrambler in its place. The parity covers the scrambled bytes, so a receiver can check it before descrambling. A frame start that arrives early ends the current frame at once. When no frame start arrives, the block keeps counting and starts a new frame by itself.

Top module: `frame_scrambler_b1`

## Requirements
- R1: While `en` is high, each rising edge loads `dout` with the processed byte and loads `sof_out` with the frame-start flag of the input byte. Both are zero after reset.
- R2: While `en` is low, `dout`, `sof_out` and all internal frame state hold their values.
- R3: A byte accepted with `sof_in` high is position 0. Each later accepted byte is one position further. After position `FRAME_LEN-1` the count returns to 0 by itself. Every byte at position 0 starts a frame, and `sof_out` follows that frame start, not the raw `sof_in`.
- R4: Bytes at positions 0 to `3*STS_N-1` are sent unchanged.
- R5: From position `3*STS_N` to the end of the frame, each byte is XORed with a key from the generator x^7+x^6+1. The generator is loaded with all ones at position `3*STS_N`. Each key byte is eight successive generator outputs, with the first output in bit 7, so the first key byte is 0xFE.
- R6: At position `90*STS_N` the block scrambles the stored parity byte in place of the input byte.
- R7: The stored parity is the XOR of all output bytes from one frame start up to the byte before the next frame start. This includes frames cut short by an early `sof_in`.
- R8: The first frame after reset carries a parity of zero, so its parity slot emits the bare key byte.
- R9: The input value presented at the parity slot has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | byte clock |
| rst_n | input | 1 | active-low synchronous reset |
| en | input | 1 | byte strobe; a byte is accepted on each edge where it is high |
| din | input | 8 | incoming byte |
| sof_in | input | 1 | marks the first framing byte of a frame |
| dout | output | 8 | processed byte, registered |
| sof_out | output | 1 | frame-start marker aligned with `dout` |

## Verification
Two things can happen on the same byte. A frame start closes the parity of the ending frame, and the same byte opens the parity of the next one. The bench forces this in an awkward place by sending an early `sof_in` in the middle of the scrambled payload, well before the natural wrap. A natural wrap with no `sof_in` provokes it as well. In both cases the frame that follows is judged at its parity slot. There the scoreboard's independently computed XOR of the truncated or flywheel frame, scrambled with the key for that position, must appear exactly.

// File: rtl/fss_pkg.sv
package fss_pkg;

  typedef struct packed {
    logic [6:0] st;
    logic [7:0] key;
  } scr_step_t;

  // Advance the x^7+x^6+1 generator by eight steps; the first output lands in bit 7.
  function automatic scr_step_t scr_advance(input logic [6:0] st_in);
    scr_step_t  r;
    logic [6:0] s;
    s = st_in;
    r.key = '0;
    for (int i = 7; i >= 0; i--) begin
      r.key[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    r.st = s;
    return r;
  endfunction

  function automatic logic [7:0] parity_fold(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

endpackage

// File: rtl/fss_frame_pos.sv
module fss_frame_pos #(
  parameter int FRAME_LEN = 3240,
  localparam int POS_W = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sof_in,
  output logic [POS_W-1:0] cur_pos,
  output logic             frame_start
);
  localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_LEN - 1);

  logic [POS_W-1:0] pos_q;

  // R3: sof_in realigns, otherwise the count free-runs and wraps
  assign cur_pos     = sof_in ? '0 : pos_q;
  assign frame_start = (cur_pos == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (en) begin
      pos_q <= (cur_pos == LAST) ? '0 : cur_pos + POS_W'(1);
    end
  end
endmodule

// File: rtl/fss_scr_key.sv
module fss_scr_key
  import fss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       reload,
  output logic [7:0] key
);
  logic [6:0] st_q;
  logic [6:0] st_use;
  scr_step_t  step;

  // R5: generator loaded with all ones at the first scrambled byte
  assign st_use = reload ? 7'h7F : st_q;
  assign step   = scr_advance(st_use);
  assign key    = step.key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= 7'h7F;
    end else if (en) begin
      st_q <= step.st;
    end
  end
endmodule

// File: rtl/fss_b1_acc.sv
module fss_b1_acc
  import fss_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       frame_start,
  input  logic [7:0] byte_out,
  output logic [7:0] b1_val
);
  logic [7:0] acc_q;
  logic [7:0] hold_q;
  logic       primed_q;

  assign b1_val = hold_q;

  // R7: close the old frame and open the new one on the same byte
  // R8: nothing is latched before the first frame has run
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      hold_q   <= '0;
      primed_q <= 1'b0;
    end else if (en) begin
      if (frame_start) begin
        hold_q   <= primed_q ? acc_q : 8'h00;
        primed_q <= 1'b1;
        acc_q    <= byte_out;
      end else begin
        acc_q <= parity_fold(acc_q, byte_out);
      end
    end
  end
endmodule

// File: rtl/frame_scrambler_b1.sv
module frame_scrambler_b1 #(
  parameter int STS_N = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [7:0] din,
  input  logic       sof_in,
  output logic [7:0] dout,
  output logic       sof_out
);
  localparam int ROW_LEN   = 90 * STS_N;
  localparam int FRAME_LEN = 9 * ROW_LEN;
  localparam int POS_W     = $clog2(FRAME_LEN);
  localparam logic [POS_W-1:0] SCR_START = POS_W'(3 * STS_N);
  localparam logic [POS_W-1:0] B1_POS    = POS_W'(ROW_LEN);

  logic [POS_W-1:0] cur_pos;
  logic             frame_start;
  logic             scr_reset;
  logic             in_clear_zone;
  logic             b1_slot;
  logic [7:0]       key;
  logic [7:0]       b1_val;
  logic [7:0]       pre_scr;
  logic [7:0]       scr_byte;

  fss_frame_pos #(.FRAME_LEN(FRAME_LEN)) u_pos (
    .clk(clk), .rst_n(rst_n), .en(en), .sof_in(sof_in),
    .cur_pos(cur_pos), .frame_start(frame_start)
  );

  assign scr_reset     = (cur_pos == SCR_START);
  assign in_clear_zone = (cur_pos < SCR_START);
  assign b1_slot       = (cur_pos == B1_POS);

  fss_scr_key u_key (
    .clk(clk), .rst_n(rst_n), .en(en), .reload(scr_reset), .key(key)
  );

  // R6 and R9: the parity replaces the input byte before scrambling
  assign pre_scr  = b1_slot ? b1_val : din;
  // R4 and R5
  assign scr_byte = in_clear_zone ? pre_scr : (pre_scr ^ key);

  fss_b1_acc u_b1 (
    .clk(clk), .rst_n(rst_n), .en(en), .frame_start(frame_start),
    .byte_out(scr_byte), .b1_val(b1_val)
  );

  // R1 and R2
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout    <= '0;
      sof_out <= 1'b0;
    end else if (en) begin
      dout    <= scr_byte;
      sof_out <= frame_start;
    end
  end
endmodule

// File: rtl/fss_checker.sv
module fss_checker #(
  parameter int POS_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [7:0]       din,
  input logic             sof_in,
  input logic [7:0]       dout,
  input logic             sof_out,
  input logic [POS_W-1:0] cur_pos,
  input logic             frame_start,
  input logic             scr_reset,
  input logic             in_clear_zone,
  input logic             b1_slot
);
  a_r1_marker: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (sof_out == $past(frame_start)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(dout) && $stable(sof_out)));

  a_r3_realign: assert property (@(posedge clk) disable iff (!rst_n)
    (en && sof_in) |-> frame_start);

  a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en && frame_start) |=> (sof_in || cur_pos == POS_W'(1)));

  a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en && in_clear_zone) |=> (dout == $past(din)));

  a_r6_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({frame_start, scr_reset, b1_slot}));
endmodule

bind frame_scrambler_b1 fss_checker #(.POS_W(POS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .din(din), .sof_in(sof_in),
  .dout(dout), .sof_out(sof_out), .cur_pos(cur_pos),
  .frame_start(frame_start), .scr_reset(scr_reset),
  .in_clear_zone(in_clear_zone), .b1_slot(b1_slot)
);

// File: tb/test_frame_scrambler_b1.sv
module test_frame_scrambler_b1;
  localparam int STS_N     = 4;
  localparam int ROW_LEN   = 90 * STS_N;
  localparam int FRAME_LEN = 9 * ROW_LEN;
  localparam int SCR_START = 3 * STS_N;
  localparam int B1_POS    = ROW_LEN;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] din = '0;
  logic       sof_in = 1'b0;
  logic [7:0] dout;
  logic       sof_out;

  frame_scrambler_b1 #(.STS_N(STS_N)) i_frame_scrambler_b1 (
    .clk(clk), .rst_n(rst_n), .en(en), .din(din), .sof_in(sof_in),
    .dout(dout), .sof_out(sof_out)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] d;
    logic       s;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   seq [127];
  bit   done = 1'b0;

  // reference model state
  int   m_pos = 0;
  int   m_acc = 0;
  int   m_b1 = 0;
  bit   m_primed = 1'b0;

  function automatic logic [7:0] key_at(input int off);
    logic [7:0] k;
    for (int b = 0; b < 8; b++) k[7-b] = seq[(8*off + b) % 127];
    return k;
  endfunction

  task automatic check(input string tag, input logic [7:0] ad, input logic as,
                       input logic [7:0] ed, input logic es);
    n_cmp++;
    if (ad !== ed || as !== es) begin
      n_bad++;
      $display("FAIL %s: dout=%02h sof_out=%0b expected dout=%02h sof_out=%0b",
               tag, ad, as, ed, es);
    end
  endtask

  task automatic send(input logic [7:0] d, input bit s);
    exp_t e;
    int cp;
    logic [7:0] bi;
    logic [7:0] o;
    cp = s ? 0 : m_pos;
    bi = (cp == B1_POS) ? 8'(m_b1) : d;
    o  = (cp < SCR_START) ? bi : (bi ^ key_at(cp - SCR_START));
    if (cp == 0) begin
      m_b1 = m_primed ? m_acc : 0;
      m_primed = 1'b1;
      m_acc = int'(o);
    end else begin
      m_acc = m_acc ^ int'(o);
    end
    m_pos = (cp == FRAME_LEN - 1) ? 0 : cp + 1;
    e.d = o;
    e.s = (cp == 0);
    if (cp < SCR_START)   e.tag = "R4 clear overhead";
    else if (cp == B1_POS) e.tag = "R6,R7,R8,R9 parity slot";
    else                  e.tag = "R5 scrambled byte";
    if (cp == 0) e.tag = {e.tag, " R3 frame start"};
    @(negedge clk);
    en = 1'b1; din = d; sof_in = s;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      en = 1'b0; din = 8'h5A; sof_in = 1'b0;
    end
  endtask

  task automatic send_frame(input int nbytes, input int pat, input bit with_sof,
                            input int gap, input logic [7:0] slot_val);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] d;
      d = (i == B1_POS) ? slot_val : 8'((i * pat + 11) & 255);
      send(d, with_sof && (i == 0));
      if (gap != 0 && (i % gap) == gap - 1) idle(1);
    end
  endtask

  // monitor: scoreboard pop after each accepted edge, hold check otherwise
  logic [7:0] last_d;
  logic       last_s;
  bit         have_last = 1'b0;
  always @(posedge clk) begin
    bit was_en;
    bit was_rst;
    exp_t e;
    was_en  = en && rst_n;
    was_rst = rst_n;
    #1;
    if (was_en) begin
      if (q.size() == 0) check("R1 unexpected byte", dout, sof_out, 8'hxx, 1'bx);
      else begin
        e = q.pop_front();
        check(e.tag, dout, sof_out, e.d, e.s);
      end
    end else if (was_rst && have_last) begin
      check("R2 hold while disabled", dout, sof_out, last_d, last_s);
    end
    last_d = dout; last_s = sof_out; have_last = was_rst;
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 7; i++) seq[i] = 1'b1;
    for (int i = 7; i < 127; i++) seq[i] = seq[i-7] ^ seq[i-6];

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", dout, sof_out, 8'h00, 1'b0);
    rst_n = 1'b1;

    // R8 first frame, gaps exercise R2
    send_frame(FRAME_LEN, 7, 1'b1, 37, 8'hA5);
    // R6 R7 R9 parity of a full frame, slot input differs
    send_frame(FRAME_LEN, 13, 1'b1, 0, 8'h3C);
    // R3 flywheel: no sof_in, wrap starts the frame
    send_frame(FRAME_LEN, 29, 1'b0, 50, 8'h00);
    // R3 R7 early frame start cuts this frame short
    send_frame(1000, 5, 1'b1, 0, 8'h00);
    send_frame(400, 3, 1'b1, 23, 8'hFF);
    idle(3);
    @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R1: %0d bytes still pending, expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule